// File: doc/BRIEF.md
# Dual Tone Burst Generator

This block drives two square-wave tones from a 1.2 MHz reference clock: a high-group tone and a low-group tone. Each tone's pitch comes from its own 8-bit divisor register. One full high-tone period lasts 6 × divisor reference cycles, and one full low-tone period lasts 12 × divisor cycles. Each half period therefore lasts 3 × divisor or 6 × divisor cycles. A tone starts high and returns low halfway through its period.

A write to the low-tone divisor starts a burst timer. By default the timer lasts 115200 cycles, which is 96 ms. Software writes the high-tone divisor first and the low-tone divisor second. When the timer runs out, neither tone is cut off. Each tone finishes its current high phase, stops on the falling edge back to its low idle level, and then rests low. Every burst is therefore made of whole pulses.

Writing the low divisor again before the timer ends extends the burst with no break. A divisor written while a tone is running takes effect at that tone's next half-period boundary, so the pitch changes without a phase jump. A divisor of 0, 1 or 2 silences its tone.

Top module: `dual_tone_gen`

## Requirements
- R1: The high tone, once started with divisor HD ≥ 3, is high for 3·HD cycles and then low for 3·HD cycles, repeating. Its period is 6·HD cycles. It goes high on the clock edge after the low-divisor strobe is sampled.
- R2: The low tone, once started with divisor LD ≥ 3, is high for 6·LD cycles and then low for 6·LD cycles. Its period is 12·LD cycles. It starts on the same edge as the high tone.
- R3: A low-divisor strobe sampled at clock edge L starts the timer. The timer is running after edges L through L+BURST_CYC−1 and stops on edge L+BURST_CYC. With both tones silent, `busy_o` is high from edge L and low from edge L+BURST_CYC.
- R4: Once the timer has stopped, each tone ends on its next falling edge and then stays low. The tone therefore emits only whole pulses: a tone with half period H that starts at edge S emits j+1 pulses, where j is the smallest value with S+(2j+1)·H−1 ≥ L+BURST_CYC.
- R5: A low-divisor strobe while the timer runs restarts the count from the new strobe edge. A strobe that lands on the same edge where the timer would stop wins, and the timer keeps running with no gap.
- R6: A divisor of 0, 1 or 2 keeps its tone low and pulse-free for the whole burst. The other tone is unaffected.
- R7: A divisor write during a burst finishes the current half period at the old length. The new length applies from the next half period onward.
- R8: `busy_o` is high while the timer runs or either tone is still active. `tone_on_o` is high while either tone is active. Both flags drop once the last tone has made its final fall.
- R9: Reset clears both divisors and the timer and forces every output low.
- R10: A high-divisor strobe on its own neither starts the timer nor starts any tone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.2 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hi_div_i | input | 8 | High-tone divisor value |
| hi_ld_i | input | 1 | Load strobe for the high-tone divisor |
| lo_div_i | input | 8 | Low-tone divisor value |
| lo_ld_i | input | 1 | Load strobe for the low-tone divisor; starts or restarts the timer |
| hi_tone_o | output | 1 | High-group tone, square wave |
| lo_tone_o | output | 1 | Low-group tone, square wave |
| tone_on_o | output | 1 | High while either tone is active |
| busy_o | output | 1 | High while the timer runs or a tone is still finishing |

## Verification
Two functions can meet on the same edge: a fresh low-divisor strobe and the expiry of the running timer. The bench provokes this by placing a second strobe exactly BURST_CYC cycles after the first. It judges the result with both tones silenced, so `busy_o` shows the timer alone: the flag must hold without a one-cycle dip and fall exactly BURST_CYC cycles after the second strobe. The same collision is then repeated with both tones running, and the bench checks their pulse counts against the extended deadline. A tone falling edge and timer expiry also meet when the bench picks a divisor whose half period equals the timer length. In that case the tone must keep `busy_o` high for exactly one more cycle.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int unsigned DIV_W_DEF   = 8;
  localparam int unsigned HI_HALF     = 3;       // half period = 3 * divisor
  localparam int unsigned LO_HALF     = 6;       // half period = 6 * divisor
  localparam int unsigned MIN_DIV     = 3;       // smaller values silence a tone
  localparam int unsigned BURST_DEF   = 115200;  // 96 ms at 1.2 MHz
  localparam int unsigned N_TONES     = 2;       // index 0 = high group, 1 = low group
endpackage

// File: rtl/burst_timer.sv
module burst_timer #(
  parameter int unsigned BURST_CYC = tone_pkg::BURST_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic run_o
);
  localparam int unsigned CNT_W = $clog2(BURST_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start_i) begin
      run_d = 1'b1;
      cnt_d = CNT_W'(BURST_CYC - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign run_o = run_q;

  p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> run_q);
  p_no_early_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0) |=> run_q);
endmodule

// File: rtl/tone_channel.sv
module tone_channel #(
  parameter int unsigned DIV_W   = tone_pkg::DIV_W_DEF,
  parameter int unsigned HALF    = tone_pkg::HI_HALF,
  parameter int unsigned MIN_DIV = tone_pkg::MIN_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             tone_o,
  output logic             active_o
);
  localparam int unsigned CNT_W = $clog2(HALF * (1 << DIV_W) + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic             tone_q, tone_d, act_q, act_d;
  logic             div_ok;

  assign div_ok  = (div_i >= DIV_W'(MIN_DIV));
  assign half_m1 = CNT_W'(HALF) * CNT_W'(div_i) - 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    tone_d = tone_q;
    act_d  = act_q;
    if (!act_q) begin
      cnt_d  = '0;
      tone_d = 1'b0;
      if (run_i && div_ok) begin
        act_d  = 1'b1;
        tone_d = 1'b1;
        cnt_d  = half_m1;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else if (!div_ok) begin
      act_d  = 1'b0;
      tone_d = 1'b0;
    end else if (tone_q && !run_i) begin
      act_d  = 1'b0;
      tone_d = 1'b0;
    end else begin
      tone_d = !tone_q;
      cnt_d  = half_m1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tone_q <= tone_d;
      act_q  <= act_d;
    end
  end

  assign tone_o   = tone_q;
  assign active_o = act_q;

  p_edge_on_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_q != $past(tone_q)) |-> ($past(cnt_q) == '0));
  p_rise_needs_divisor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_q) |-> ($past(div_i) >= DIV_W'(MIN_DIV)));
  p_stop_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> (!tone_q && ($past(!run_i) || $past(div_i) < DIV_W'(MIN_DIV))));
  p_idle_is_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !tone_q);
endmodule

// File: rtl/dual_tone_gen.sv
module dual_tone_gen #(
  parameter int unsigned DIV_W     = tone_pkg::DIV_W_DEF,
  parameter int unsigned BURST_CYC = tone_pkg::BURST_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] hi_div_i,
  input  logic             hi_ld_i,
  input  logic [DIV_W-1:0] lo_div_i,
  input  logic             lo_ld_i,
  output logic             hi_tone_o,
  output logic             lo_tone_o,
  output logic             tone_on_o,
  output logic             busy_o
);
  import tone_pkg::*;

  logic [N_TONES-1:0][DIV_W-1:0] div_q;
  logic [N_TONES-1:0][DIV_W-1:0] div_new;
  logic [N_TONES-1:0]            div_en;
  logic [N_TONES-1:0]            tone, act;
  logic                          run;

  assign div_new = {lo_div_i, hi_div_i};
  assign div_en  = {lo_ld_i, hi_ld_i};

  burst_timer #(.BURST_CYC(BURST_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (lo_ld_i),
    .run_o   (run)
  );

  for (genvar g = 0; g < N_TONES; g++) begin : g_tone
    localparam int unsigned HALF_G = (g == 0) ? HI_HALF : LO_HALF;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         div_q[g] <= '0;
      else if (div_en[g]) div_q[g] <= div_new[g];
    end

    tone_channel #(.DIV_W(DIV_W), .HALF(HALF_G), .MIN_DIV(MIN_DIV)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_i    (div_q[g]),
      .run_i    (run),
      .tone_o   (tone[g]),
      .active_o (act[g])
    );
  end

  assign hi_tone_o = tone[0];
  assign lo_tone_o = tone[1];
  assign tone_on_o = |act;
  assign busy_o    = run | (|act);

  p_low_load_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_ld_i |=> busy_o);
  p_high_load_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !lo_ld_i) |=> !busy_o);
  p_tones_need_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_tone_o || lo_tone_o) |-> tone_on_o);
endmodule

// File: tb/test_dual_tone_gen.sv
module test_dual_tone_gen;
  localparam int CLK_PERIOD = 10;
  localparam int B          = 600;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hi_div = '0, lo_div = '0;
  logic       hi_ld = 1'b0, lo_ld = 1'b0;
  logic       hi_tone, lo_tone, tone_on, busy;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit mon_en = 0;
  int hi_hc, lo_hc, hi_np, lo_np;
  logic hi_prev, lo_prev;
  int rl [0:7];
  int ri, cur;
  bit started;
  int L, Llast;

  dual_tone_gen #(.DIV_W(8), .BURST_CYC(B)) i_dual_tone_gen (
    .clk(clk), .rst_n(rst_n),
    .hi_div_i(hi_div), .hi_ld_i(hi_ld),
    .lo_div_i(lo_div), .lo_ld_i(lo_ld),
    .hi_tone_o(hi_tone), .lo_tone_o(lo_tone),
    .tone_on_o(tone_on), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (mon_en) begin
    hi_hc += int'(hi_tone);
    lo_hc += int'(lo_tone);
    if (hi_tone && !hi_prev) hi_np++;
    if (lo_tone && !lo_prev) lo_np++;
    if (hi_tone != hi_prev) begin
      if (started && ri < 8) rl[ri] = cur;
      if (started) ri++;
      if (hi_tone) started = 1;
      cur = 1;
    end else cur++;
    hi_prev = hi_tone;
    lo_prev = lo_tone;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  function automatic int exp_np(input int d, input int half, input int s, input int lend);
    int h = half * d;
    int j = 0;
    if (d < 3) return 0;
    while (s + (2*j+1)*h - 1 < lend + B) j++;
    return j + 1;
  endfunction

  task automatic clear_mon();
    hi_hc = 0; lo_hc = 0; hi_np = 0; lo_np = 0;
    hi_prev = 1'b0; lo_prev = 1'b0; ri = 0; cur = 0; started = 0;
    for (int k = 0; k < 8; k++) rl[k] = 0;
  endtask

  // Load high divisor, then low divisor (timer start at edge L); optional restart at L+ext.
  task automatic start_burst(input logic [7:0] hd, input logic [7:0] ldv, input int ext);
    @(negedge clk); hi_div = hd; hi_ld = 1'b1;
    @(negedge clk); hi_ld = 1'b0; lo_div = ldv; lo_ld = 1'b1;
    L = cyc + 1; Llast = L; clear_mon(); mon_en = 1;
    @(negedge clk); lo_ld = 1'b0;
    if (ext > 0) begin
      wait_cyc(L + ext - 1);
      lo_ld = 1'b1; Llast = cyc + 1;
      @(negedge clk); lo_ld = 1'b0;
    end
  endtask

  task automatic finish_burst();
    int guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    mon_en = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [7:0] lv;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 hi_tone reset", hi_tone, 0);
    check("R9 lo_tone reset", lo_tone, 0);
    check("R9 busy reset", busy, 0);
    check("R9 tone_on reset", tone_on, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: high-divisor load alone
    hi_div = 8'd5; hi_ld = 1'b1;
    @(negedge clk); hi_ld = 1'b0;
    repeat (40) @(negedge clk);
    check("R10 busy after high load only", busy, 0);
    check("R10 hi_tone after high load only", hi_tone, 0);

    // R1/R2/R4/R6: sweep divisors
    for (int d = 0; d <= 40; d++) begin
      lv = 8'((d*3 + 1) % 23);
      start_burst(8'(d), lv, 0);
      check("R3 busy right after low load", busy, 1);
      finish_burst();
      check((d < 3) ? "R6 hi pulses silenced" : "R1 R4 hi pulse count",
            hi_np, exp_np(d, 3, L+1, Llast));
      check("R1 hi high cycles", hi_hc, exp_np(d, 3, L+1, Llast) * 3 * d);
      check((lv < 3) ? "R6 lo pulses silenced" : "R2 R4 lo pulse count",
            lo_np, exp_np(lv, 6, L+1, Llast));
      check("R2 lo high cycles", lo_hc, exp_np(lv, 6, L+1, Llast) * 6 * int'(lv));
    end

    // R3: exact timer length with both tones silent
    start_burst(8'd0, 8'd0, 0);
    wait_cyc(L + B - 1);
    check("R3 busy last timer cycle", busy, 1);
    wait_cyc(L + B);
    check("R3 busy after expiry", busy, 0);
    finish_burst();

    // R8: tone still high at expiry keeps busy one more cycle (half period = B)
    start_burst(8'd200, 8'd0, 0);
    wait_cyc(L + 10);
    check("R8 tone_on during burst", tone_on, 1);
    wait_cyc(L + B);
    check("R8 busy while tone finishes", busy, 1);
    check("R8 hi_tone still high at expiry", hi_tone, 1);
    wait_cyc(L + B + 1);
    check("R8 busy after final fall", busy, 0);
    check("R8 tone_on after final fall", tone_on, 0);
    finish_burst();

    // R5: restart before expiry
    start_burst(8'd7, 8'd9, 300);
    finish_burst();
    check("R5 hi pulses extended", hi_np, exp_np(7, 3, L+1, Llast));
    check("R5 lo pulses extended", lo_np, exp_np(9, 6, L+1, Llast));

    // R5: restart on the expiry edge, tones silent
    start_burst(8'd0, 8'd0, B);
    wait_cyc(L + B);
    check("R5 busy no gap at collision", busy, 1);
    wait_cyc(L + 2*B - 1);
    check("R5 busy before extended expiry", busy, 1);
    wait_cyc(L + 2*B);
    check("R5 busy after extended expiry", busy, 0);
    finish_burst();

    // R5: same collision with tones running
    start_burst(8'd5, 8'd11, B);
    finish_burst();
    check("R5 collision hi pulses", hi_np, exp_np(5, 3, L+1, Llast));
    check("R5 collision lo pulses", lo_np, exp_np(11, 6, L+1, Llast));

    // R7: phase-continuous change mid half period
    start_burst(8'd10, 8'd0, 0);
    wait_cyc(L + 15);
    hi_div = 8'd20; hi_ld = 1'b1;
    @(negedge clk); hi_ld = 1'b0;
    finish_burst();
    check("R7 first high keeps old length", rl[0], 30);
    check("R7 next low uses new length", rl[1], 60);
    check("R7 next high uses new length", rl[2], 60);

    // R9: reset during a burst
    start_burst(8'd4, 8'd4, 0);
    wait_cyc(L + 20);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 busy after mid reset", busy, 0);
    check("R9 tones after mid reset", int'(hi_tone) + int'(lo_tone), 0);
    rst_n = 1'b1;
    mon_en = 0;
    repeat (2) @(negedge clk);

    summary();
  end
endmodule